// File: doc/BRIEF.md
# Next Program Counter Unit

This block owns the program counter of a simple in-order core that uses 32-bit fixed-length instructions. Each cycle it looks at the instruction word currently addressed by the program counter. It also takes the equality result from the register comparator and the value of the source register named by a register jump. From these it picks the program counter for the following cycle. The choices are the next sequential word, a PC-relative conditional branch, a pseudo-direct absolute jump, or a jump through a register.

For subroutine calls the block also supplies the return address and a one-cycle write strobe. The register file uses these to store the return address. A synchronous reset loads a start address that is fixed by a parameter. A stall input freezes the program counter and suppresses the link write, so that a stalled call is not committed twice.

Top module: `next_pc_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `pc_o` becomes the parameter `START_ADDR` and `link_we_o` is low.
- R2: Any instruction that is not a branch, jump or register jump moves `pc_o` to `pc_o + 4` at the next unstalled edge. This includes opcode 0 (bits 31:26) with a funct value (bits 5:0) other than 8.
- R3: Opcode 4 is the branch-if-equal. When `regs_equal_i` is high, the next PC is `pc_o + 4 + (sign-extended bits 15:0) * 4`. Otherwise it is `pc_o + 4`.
- R4: Opcode 5 is the branch-if-not-equal. It takes the same target when `regs_equal_i` is low and falls through to `pc_o + 4` when it is high.
- R5: The 16-bit offset is sign-extended, so an offset with bit 15 set produces a backward target.
- R6: Opcode 2 is the absolute jump. The next PC is made of bits 31:28 of the current PC, then instruction bits 25:0, then two zero bits.
- R7: Opcode 3 is the call. It takes the same target as R6. In the cycle it is presented unstalled, `link_we_o` is high and `link_addr_o` equals `pc_o + 4`.
- R8: Opcode 0 with funct 8 loads the next PC from `jump_reg_i`.
- R9: While `stall_i` is high, `pc_o` holds its value and `link_we_o` is low, whatever the instruction.
- R10: `link_we_o` is low for every opcode other than 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| stall_i | input | 1 | Hold the PC and suppress the link write |
| instr_i | input | 32 | Instruction word at the current PC |
| regs_equal_i | input | 1 | High when the two compared source registers are equal |
| jump_reg_i | input | 32 | Source register value used by the register jump |
| pc_o | output | 32 | Current program counter |
| link_addr_o | output | 32 | Return address for a call (PC + 4) |
| link_we_o | output | 1 | Write strobe for the return register |

## Verification
Both conditional branches are driven with the comparator result high and low. A design that swaps their polarity or ignores the compare therefore gives a wrong PC. Forward and backward offsets are used, which separates a sign-extended offset from a zero-extended one and shows whether the offset is scaled by four. Jumps are issued from a PC whose upper nibble is non-zero, so that keeping the old top bits can be told apart from clearing them. An opcode-0 word with a funct value other than 8 checks that only the register jump leaves sequential flow. Stalled calls check that neither the PC nor the link strobe moves.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int ADDR_W    = 32;
    localparam int OPC_W     = 6;
    localparam int FUNCT_W   = 6;
    localparam int JFIELD_W  = 26;
    localparam int OFFSET_W  = 16;
    localparam int WORD_SHIFT = 2;
    localparam int KEEP_W    = ADDR_W - JFIELD_W - WORD_SHIFT;

    localparam logic [OPC_W-1:0]   OPC_SPECIAL = 6'd0;
    localparam logic [OPC_W-1:0]   OPC_JUMP    = 6'd2;
    localparam logic [OPC_W-1:0]   OPC_CALL    = 6'd3;
    localparam logic [OPC_W-1:0]   OPC_BR_EQ   = 6'd4;
    localparam logic [OPC_W-1:0]   OPC_BR_NE   = 6'd5;
    localparam logic [FUNCT_W-1:0] FN_REG_JUMP = 6'd8;

    typedef enum logic [1:0] {
        FLOW_SEQ    = 2'd0,
        FLOW_BRANCH = 2'd1,
        FLOW_ABS    = 2'd2,
        FLOW_REG    = 2'd3
    } flow_e;

    typedef struct packed {
        flow_e flow;
        logic  br_on_ne;
        logic  is_call;
    } flow_dec_t;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
    } pc_state_t;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [OPC_W-1:0]   opcode_i,
    input  logic [FUNCT_W-1:0] funct_i,
    output flow_dec_t          dec_o
);

    always_comb begin
        dec_o.flow     = FLOW_SEQ;
        dec_o.br_on_ne = 1'b0;
        dec_o.is_call  = 1'b0;
        unique case (opcode_i)
            OPC_SPECIAL: begin
                if (funct_i == FN_REG_JUMP) begin
                    dec_o.flow = FLOW_REG;
                end
            end
            OPC_JUMP: begin
                dec_o.flow = FLOW_ABS;
            end
            OPC_CALL: begin
                dec_o.flow    = FLOW_ABS;
                dec_o.is_call = 1'b1;
            end
            OPC_BR_EQ: begin
                dec_o.flow = FLOW_BRANCH;
            end
            OPC_BR_NE: begin
                dec_o.flow     = FLOW_BRANCH;
                dec_o.br_on_ne = 1'b1;
            end
            default: begin
                dec_o.flow = FLOW_SEQ;
            end
        endcase
    end

endmodule

// File: rtl/npc_targets.sv
module npc_targets
    import npc_pkg::*;
(
    input  logic [ADDR_W-1:0]   pc_i,
    input  logic [JFIELD_W-1:0] jfield_i,
    output logic [ADDR_W-1:0]   seq_o,
    output logic [ADDR_W-1:0]   branch_o,
    output logic [ADDR_W-1:0]   abs_o
);

    localparam int EXT_W = ADDR_W - OFFSET_W - WORD_SHIFT;

    logic [OFFSET_W-1:0] offset;
    logic [ADDR_W-1:0]   byte_disp;

    always_comb begin
        offset    = jfield_i[OFFSET_W-1:0];
        byte_disp = {{EXT_W{offset[OFFSET_W-1]}}, offset, {WORD_SHIFT{1'b0}}};
        seq_o     = pc_i + ADDR_W'(4);
        branch_o  = seq_o + byte_disp;
        abs_o     = {pc_i[ADDR_W-1 -: KEEP_W], jfield_i, {WORD_SHIFT{1'b0}}};
    end

endmodule

// File: rtl/next_pc_unit.sv
module next_pc_unit
    import npc_pkg::*;
#(
    parameter logic [31:0] START_ADDR = 32'h0040_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        stall_i,
    input  logic [31:0] instr_i,
    input  logic        regs_equal_i,
    input  logic [31:0] jump_reg_i,
    output logic [31:0] pc_o,
    output logic [31:0] link_addr_o,
    output logic        link_we_o
);

    pc_state_t         state_d;
    pc_state_t         state_q;
    flow_dec_t         dec;
    logic [ADDR_W-1:0] seq_tgt;
    logic [ADDR_W-1:0] br_tgt;
    logic [ADDR_W-1:0] abs_tgt;
    logic              br_taken;

    npc_decode u_decode (
        .opcode_i (instr_i[ADDR_W-1 -: OPC_W]),
        .funct_i  (instr_i[FUNCT_W-1:0]),
        .dec_o    (dec)
    );

    npc_targets u_targets (
        .pc_i     (state_q.pc),
        .jfield_i (instr_i[JFIELD_W-1:0]),
        .seq_o    (seq_tgt),
        .branch_o (br_tgt),
        .abs_o    (abs_tgt)
    );

    always_comb begin
        state_d  = state_q;
        br_taken = dec.br_on_ne ? !regs_equal_i : regs_equal_i;
        if (rst) begin
            state_d.pc = START_ADDR;
        end else if (!stall_i) begin
            unique case (dec.flow)
                FLOW_BRANCH: state_d.pc = br_taken ? br_tgt : seq_tgt;
                FLOW_ABS:    state_d.pc = abs_tgt;
                FLOW_REG:    state_d.pc = jump_reg_i;
                default:     state_d.pc = seq_tgt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign pc_o        = state_q.pc;
    assign link_addr_o = seq_tgt;
    assign link_we_o   = dec.is_call && !stall_i && !rst;

    a_r9_stall_hold: assert property (@(posedge clk) disable iff (rst)
        stall_i |=> $stable(pc_o));

    a_r9_no_link_on_stall: assert property (@(posedge clk) disable iff (rst)
        stall_i |-> !link_we_o);

    a_r2_seq_step: assert property (@(posedge clk) disable iff (rst)
        (!stall_i && dec.flow == FLOW_SEQ) |=> pc_o == $past(pc_o) + 32'd4);

    a_r6_abs_keeps_top: assert property (@(posedge clk) disable iff (rst)
        (!stall_i && dec.flow == FLOW_ABS) |=> pc_o[31:28] == $past(pc_o[31:28]));

    a_r10_link_only_call: assert property (@(posedge clk) disable iff (rst)
        link_we_o |-> instr_i[31:26] == 6'd3);

    a_r7_link_value: assert property (@(posedge clk) disable iff (rst)
        link_we_o |-> link_addr_o == pc_o + 32'd4);

    a_r8_reg_jump_load: assert property (@(posedge clk) disable iff (rst)
        (!stall_i && instr_i[31:26] == 6'd0 && instr_i[5:0] == 6'd8)
            |=> pc_o == $past(jump_reg_i));

endmodule

// File: tb/next_pc_unit_tb_top.sv
`timescale 1ns/1ps
module next_pc_unit_tb_top;

    localparam logic [31:0] START = 32'h0040_0000;

    logic        clk = 1'b0;
    logic        rst;
    logic        stall_i;
    logic [31:0] instr_i;
    logic        regs_equal_i;
    logic [31:0] jump_reg_i;
    logic [31:0] pc_o;
    logic [31:0] link_addr_o;
    logic        link_we_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    next_pc_unit #(.START_ADDR(START)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .stall_i      (stall_i),
        .instr_i      (instr_i),
        .regs_equal_i (regs_equal_i),
        .jump_reg_i   (jump_reg_i),
        .pc_o         (pc_o),
        .link_addr_o  (link_addr_o),
        .link_we_o    (link_we_o)
    );

    function automatic logic [31:0] mk_br(input logic [5:0] opc, input logic [15:0] off);
        return {opc, 5'd8, 5'd9, off};
    endfunction

    function automatic logic [31:0] mk_abs(input logic [5:0] opc, input logic [25:0] fld);
        return {opc, fld};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive at negedge, clock once, sample at the following negedge
    task automatic step(input logic [31:0] ins, input logic eq, input logic [31:0] rv,
                        input logic stl);
        instr_i = ins; regs_equal_i = eq; jump_reg_i = rv; stall_i = stl;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic go_to(input logic [31:0] addr);
        step({6'd0, 5'd31, 15'd0, 6'd8}, 1'b0, addr, 1'b0);
    endtask

    task automatic t_reset();
        rst = 1'b1; stall_i = 1'b0; instr_i = 32'h0; regs_equal_i = 1'b0; jump_reg_i = 32'h0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R1 reset pc", pc_o, START);
        check("R1 reset link_we", {31'd0, link_we_o}, 32'd0);
        rst = 1'b0;
    endtask

    task automatic t_sequential();
        logic [31:0] p;
        p = pc_o;
        step(32'h0232_4020, 1'b1, 32'hDEAD_BEEF, 1'b0);
        check("R2 add word +4", pc_o, p + 32'd4);
        p = pc_o;
        step(32'h8C00_0000, 1'b1, 32'h0, 1'b0);
        check("R2 load word +4", pc_o, p + 32'd4);
    endtask

    task automatic t_branch_eq();
        logic [31:0] p;
        p = pc_o;
        step(mk_br(6'd4, 16'd3), 1'b1, 32'h0, 1'b0);
        check("R3 beq taken", pc_o, p + 32'd4 + 32'd12);
        p = pc_o;
        step(mk_br(6'd4, 16'd3), 1'b0, 32'h0, 1'b0);
        check("R3 beq not taken", pc_o, p + 32'd4);
    endtask

    task automatic t_branch_ne();
        logic [31:0] p;
        p = pc_o;
        step(mk_br(6'd5, 16'd7), 1'b0, 32'h0, 1'b0);
        check("R4 bne taken", pc_o, p + 32'd4 + 32'd28);
        p = pc_o;
        step(mk_br(6'd5, 16'd7), 1'b1, 32'h0, 1'b0);
        check("R4 bne not taken", pc_o, p + 32'd4);
    endtask

    task automatic t_backward();
        logic [31:0] p;
        p = pc_o;
        step(mk_br(6'd4, 16'hFFFE), 1'b1, 32'h0, 1'b0);
        check("R5 backward beq", pc_o, p + 32'd4 - 32'd8);
        p = pc_o;
        step(mk_br(6'd5, 16'h8000), 1'b0, 32'h0, 1'b0);
        check("R5 most negative bne", pc_o, p + 32'd4 - 32'h0002_0000);
    endtask

    task automatic t_jump();
        go_to(32'h9000_0010);
        check("R8 jr load", pc_o, 32'h9000_0010);
        step(mk_abs(6'd2, 26'h000_0040), 1'b0, 32'h0, 1'b0);
        check("R6 j keeps top nibble", pc_o, 32'h9000_0100);
        check("R10 no link after j", {31'd0, link_we_o}, 32'd0);
    endtask

    task automatic t_call();
        logic [31:0] p;
        go_to(32'h0000_0104);
        p = pc_o;
        instr_i = mk_abs(6'd3, 26'h000_0400); regs_equal_i = 1'b0; stall_i = 1'b0;
        #1;
        check("R7 link strobe", {31'd0, link_we_o}, 32'd1);
        check("R7 link addr", link_addr_o, 32'h0000_0108);
        step(mk_abs(6'd3, 26'h000_0400), 1'b0, 32'h0, 1'b0);
        check("R7 call target", pc_o, {p[31:28], 26'h000_0400, 2'b00});
    endtask

    task automatic t_special_other();
        logic [31:0] p;
        p = pc_o;
        instr_i = {6'd0, 5'd31, 15'd0, 6'd9}; #1;
        check("R10 no link opcode0", {31'd0, link_we_o}, 32'd0);
        step({6'd0, 5'd31, 15'd0, 6'd9}, 1'b0, 32'h1234_5678, 1'b0);
        check("R2 opcode0 funct9 sequential", pc_o, p + 32'd4);
    endtask

    task automatic t_stall();
        logic [31:0] p;
        p = pc_o;
        instr_i = mk_abs(6'd3, 26'h0AB_CDEF); stall_i = 1'b1; #1;
        check("R9 no link when stalled", {31'd0, link_we_o}, 32'd0);
        step(mk_abs(6'd3, 26'h0AB_CDEF), 1'b0, 32'h0, 1'b1);
        check("R9 pc held on call", pc_o, p);
        step(mk_br(6'd4, 16'd5), 1'b1, 32'h0, 1'b1);
        check("R9 pc held on branch", pc_o, p);
        stall_i = 1'b0;
    endtask

    task automatic t_reset_midrun();
        rst = 1'b1;
        step(mk_abs(6'd3, 26'h123_4567), 1'b0, 32'h0, 1'b0);
        check("R1 reset over call", pc_o, START);
        rst = 1'b0;
    endtask

    initial begin
        t_reset();
        t_sequential();
        t_branch_eq();
        t_branch_ne();
        t_backward();
        t_jump();
        t_call();
        t_special_other();
        t_stall();
        t_reset_midrun();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule